// File: doc/BRIEF.md
# CAN Controller Control Register Unit

This block is the mode and command register of a CAN controller. It is split into two byte-wide halves on a small register bus. The low half holds the initialization-mode bit and six mode bits: loopback, byte message order, basic mode, bus-error interrupt enable, sleep and port enable. The high half holds a time-stamp prescale select, a listen-only bit and two command bits that clear themselves. Software sets the initialization bit, waits until the status output confirms it, and then changes the configuration. Outside initialization mode the configuration fields are locked. The command bits are not locked and can be used at any time.

The unit also holds the 16-bit time-stamp counter and the transmit and receive error counters. The bit-timing engine supplies a bit-tick input at eight pulses per bit time. The time-stamp counter divides this by 8, 4, 2 or 1. The error-counting logic is outside the block and supplies one increment strobe per counter. A transmit request passes through the block and is blocked while listen-only is selected.

Top module: `can_ctrl_regs`

## Requirements
- R1: After reset, the low byte reads 01h in bits 6..0. The high byte reads 0 in bits 0, 1, 2, 3 and 5. The time-stamp counter and both error counters are 0. The status output is 1.
- R2: Low-byte bits 6..1 (bit 1 loopback, bit 2 byte order, bit 3 basic mode, bit 4 bus-error interrupt enable, bit 5 sleep, bit 6 port enable) take a written value only when the init bit (bit 0) was 1 before the write. Otherwise they keep their value. Bit 0 can always be written.
- R3: High-byte bits 1:0 (prescale) and bit 5 (listen-only) take a written value only when the init bit was 1 before the write. Otherwise they keep their value.
- R4: The time-stamp counter advances once per 8, 4, 2 or 1 bit-tick pulses for prescale 00, 01, 10 or 11. It wraps from FFFFh to 0000h.
- R5: Writing 1 to high-byte bit 2 sets the time-stamp counter and its prescale phase to 0 at that clock edge. Bit 2 reads 1 for one cycle and then 0. A bit tick in the same cycle is lost.
- R6: Writing 1 to high-byte bit 3 sets both error counters to 00h at that clock edge. Bit 3 reads 1 for one cycle and then 0. An increment strobe in the same cycle is lost.
- R7: While listen-only is 1, the transmit-request output is 0. Otherwise it follows the transmit-request input.
- R8: The status output equals the init bit as it was one clock earlier.
- R9: Each error counter increments by one on its strobe and saturates at FFh.
- R10: Reads are combinational. Address 0 returns the low byte and address 1 returns the high byte. Unimplemented bits (low 7, high 4, 6, 7) ignore writes and are don't-care on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle byte write enable |
| bus_addr | input | 1 | Byte select: 0 low half, 1 high half |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| bit_tick | input | 1 | Eight pulses per bit time |
| tec_inc | input | 1 | Transmit error counter increment strobe |
| rec_inc | input | 1 | Receive error counter increment strobe |
| tx_req | input | 1 | Transmit request from the frame logic |
| tx_grant | output | 1 | Transmit request after the listen-only block |
| init_mode | output | 1 | Initialization-mode bit |
| loopback | output | 1 | Loopback select |
| msg_byte_order | output | 1 | Byte message-order select |
| basic_mode | output | 1 | Basic-mode select |
| buserr_ie | output | 1 | Bus-error interrupt enable |
| sleep_en | output | 1 | Sleep select |
| port_en | output | 1 | Pins assigned to the controller |
| listen_only | output | 1 | Listen-only select |
| ts_scale | output | 2 | Time-stamp prescale select |
| in_reset | output | 1 | Status: controller in initialization mode |
| ts_count | output | 16 | Time-stamp counter |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter |

## Verification
Two pairs of events can fall on the same edge: a self-clearing clear command and the increment of the counter it clears. The bench drives a time-stamp reset write together with a bit tick, after the counter has been brought to a nonzero value with the fastest prescale. In a separate case it drives a bus-off return write together with both error strobes, after both counters have been loaded. Each case passes only if the affected counters read zero right after that edge and the command bit reads 1 for exactly one cycle.

// File: rtl/can_ctrl_pkg.sv
package can_ctrl_pkg;
    localparam int BYTE_W = 8;
    localparam int PS_W   = 2;

    // low byte bit positions
    localparam int LB_INIT  = 0;
    localparam int LB_LOOP  = 1;
    localparam int LB_ORDER = 2;
    localparam int LB_BASIC = 3;
    localparam int LB_BEIE  = 4;
    localparam int LB_SLEEP = 5;
    localparam int LB_PORT  = 6;
    // high byte bit positions
    localparam int HB_TSRST = 2;
    localparam int HB_BOFF  = 3;
    localparam int HB_LISTN = 5;

    typedef struct packed {
        logic            init;
        logic            loopback;
        logic            order;
        logic            basic;
        logic            beie;
        logic            sleep;
        logic            port;
        logic [PS_W-1:0] ps;
        logic            listen;
        logic            ts_cmd;
        logic            bo_cmd;
        logic            sts;
    } ctl_t;
endpackage

// File: rtl/can_ts_counter.sv
module can_ts_counter #(
    parameter int TS_W    = 16,
    parameter int DIV_LOG = 3,
    parameter int PS_W    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [PS_W-1:0] ps,
    input  logic            clr,
    output logic [TS_W-1:0] count
);
    localparam logic [DIV_LOG:0] PRE_N = (DIV_LOG+1)'(1 << DIV_LOG);

    typedef struct packed {
        logic [DIV_LOG-1:0] pre;
        logic [TS_W-1:0]    cnt;
    } ts_t;

    ts_t ts_d, ts_q;
    logic [DIV_LOG:0] term;

    always_comb begin
        ts_d = ts_q;
        term = (PRE_N >> ps) - (DIV_LOG+1)'(1);
        if (clr) begin
            ts_d.pre = '0;
            ts_d.cnt = '0;
        end else if (tick) begin
            if ({1'b0, ts_q.pre} >= term) begin
                ts_d.pre = '0;
                ts_d.cnt = ts_q.cnt + TS_W'(1);
            end else begin
                ts_d.pre = ts_q.pre + DIV_LOG'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign count = ts_q.cnt;

    // R5: clear empties the counter at the next edge, tick or not
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
    // R4: without a tick the counter holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(count));
endmodule

// File: rtl/can_err_counter.sv
module can_err_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                      cnt_d = '0;
        else if (inc && cnt_q != '1)  cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R6: clear wins over increment
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
    // R9: saturated counter stays at maximum until cleared
    p_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '1 && !clr) |=> (count == '1));
endmodule

// File: rtl/can_ctrl_regs.sv
module can_ctrl_regs
    import can_ctrl_pkg::*;
#(
    parameter int TS_W    = 16,
    parameter int EC_W    = 8,
    parameter int DIV_LOG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              bit_tick,
    input  logic              tec_inc,
    input  logic              rec_inc,
    input  logic              tx_req,
    output logic              tx_grant,
    output logic              init_mode,
    output logic              loopback,
    output logic              msg_byte_order,
    output logic              basic_mode,
    output logic              buserr_ie,
    output logic              sleep_en,
    output logic              port_en,
    output logic              listen_only,
    output logic [PS_W-1:0]   ts_scale,
    output logic              in_reset,
    output logic [TS_W-1:0]   ts_count,
    output logic [EC_W-1:0]   tec,
    output logic [EC_W-1:0]   rec
);
    localparam ctl_t CTL_RST = '{init: 1'b1, sts: 1'b1, default: '0};
    localparam int   N_EC    = 2;

    ctl_t ctl_d, ctl_q;
    logic wr_lo, wr_hi, ts_clr, bo_clr;

    assign wr_lo  = bus_wr && !bus_addr;
    assign wr_hi  = bus_wr &&  bus_addr;
    assign ts_clr = wr_hi && bus_wdata[HB_TSRST];
    assign bo_clr = wr_hi && bus_wdata[HB_BOFF];

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.sts    = ctl_q.init;
        ctl_d.ts_cmd = ts_clr;
        ctl_d.bo_cmd = bo_clr;
        if (wr_lo) begin
            ctl_d.init = bus_wdata[LB_INIT];
            if (ctl_q.init) begin
                ctl_d.loopback = bus_wdata[LB_LOOP];
                ctl_d.order    = bus_wdata[LB_ORDER];
                ctl_d.basic    = bus_wdata[LB_BASIC];
                ctl_d.beie     = bus_wdata[LB_BEIE];
                ctl_d.sleep    = bus_wdata[LB_SLEEP];
                ctl_d.port     = bus_wdata[LB_PORT];
            end
        end
        if (wr_hi && ctl_q.init) begin
            ctl_d.ps     = bus_wdata[PS_W-1:0];
            ctl_d.listen = bus_wdata[HB_LISTN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        if (!bus_addr)
            bus_rdata = {1'b0, ctl_q.port, ctl_q.sleep, ctl_q.beie,
                         ctl_q.basic, ctl_q.order, ctl_q.loopback, ctl_q.init};
        else
            bus_rdata = {2'b00, ctl_q.listen, 1'b0, ctl_q.bo_cmd,
                         ctl_q.ts_cmd, ctl_q.ps};
    end

    assign init_mode      = ctl_q.init;
    assign loopback       = ctl_q.loopback;
    assign msg_byte_order = ctl_q.order;
    assign basic_mode     = ctl_q.basic;
    assign buserr_ie      = ctl_q.beie;
    assign sleep_en       = ctl_q.sleep;
    assign port_en        = ctl_q.port;
    assign listen_only    = ctl_q.listen;
    assign ts_scale       = ctl_q.ps;
    assign in_reset       = ctl_q.sts;
    assign tx_grant       = tx_req && !ctl_q.listen;

    can_ts_counter #(.TS_W(TS_W), .DIV_LOG(DIV_LOG), .PS_W(PS_W)) u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_tick),
        .ps    (ctl_q.ps),
        .clr   (ts_clr),
        .count (ts_count)
    );

    logic [N_EC-1:0]           ec_inc;
    logic [N_EC-1:0][EC_W-1:0] ec_val;
    assign ec_inc = {rec_inc, tec_inc};

    for (genvar g = 0; g < N_EC; g++) begin : g_ec
        can_err_counter #(.W(EC_W)) u_ec (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ec_inc[g]),
            .clr   (bo_clr),
            .count (ec_val[g])
        );
    end

    assign tec = ec_val[0];
    assign rec = ec_val[1];

    // R2: locked mode bits keep their value outside init mode
    p_lock_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !init_mode) |=> $stable({port_en, sleep_en, buserr_ie,
                                            basic_mode, msg_byte_order, loopback}));
    // R3: prescale and listen-only locked outside init mode
    p_lock_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !init_mode) |=> $stable({ts_scale, listen_only}));
    // R5: time-stamp command bit lasts one cycle
    p_selfclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ts_cmd && !ts_clr) |=> !ctl_q.ts_cmd);
    // R6: bus-off command bit lasts one cycle
    p_selfclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.bo_cmd && !bo_clr) |=> !ctl_q.bo_cmd);
    // R7: no transmit request leaves while listening only
    p_listen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        listen_only |-> !tx_grant);
    // R8: status lags the init bit by one clock
    p_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (in_reset == $past(init_mode)));
endmodule

// File: tb/sim_can_ctrl_regs.sv
module sim_can_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic        bit_tick = 1'b0, tec_inc = 1'b0, rec_inc = 1'b0, tx_req = 1'b0;
    logic        tx_grant, init_mode, loopback, msg_byte_order, basic_mode;
    logic        buserr_ie, sleep_en, port_en, listen_only, in_reset;
    logic [1:0]  ts_scale;
    logic [15:0] ts_count;
    logic [7:0]  tec, rec;

    int n_chk = 0, n_err = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    can_ctrl_regs u0 (.*);

    // {addr, wdata, mask, expected}
    localparam int NV = 7;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 8'h7F, 8'h7F, 8'h7F},  // R2 all mode bits while init
        {1'b1, 8'h23, 8'h23, 8'h23},  // R3 prescale 11, listen-only
        {1'b0, 8'h00, 8'h7F, 8'h00},  // R2 leave init, clear bits
        {1'b0, 8'h7E, 8'h7F, 8'h00},  // R2 locked: ignored
        {1'b1, 8'h00, 8'h23, 8'h23},  // R3 locked: ignored
        {1'b0, 8'h01, 8'h7F, 8'h01},  // R2 re-enter init
        {1'b1, 8'h01, 8'h23, 8'h01}   // R3 prescale 01, listen off
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called and returns just after a falling edge
    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            @(negedge clk);
        end
        bit_tick = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); check("R1 low", {24'd0, v & 8'h7F}, 32'h01);
        rd(1'b1, v); check("R1 high", {24'd0, v & 8'h2F}, 32'h00);
        check("R1 ts", {16'd0, ts_count}, 0);
        check("R1 ec", {16'd0, tec, rec}, 0);
        check("R1 sts", {31'd0, in_reset}, 1);

        // R2 R3 R10 table walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][24], VEC[i][23:16]);
            rd(VEC[i][24], v);
            check(VEC[i][24] ? "R3 R10 vec" : "R2 R10 vec",
                  {24'd0, v & VEC[i][15:8]}, {24'd0, VEC[i][7:0]});
        end

        // R7 listen-only gating (init still 1)
        wr(1'b1, 8'h20); tx_req = 1'b1; #0.5;
        check("R7 blocked", {31'd0, tx_grant}, 0);
        wr(1'b1, 8'h00); #0.5;
        check("R7 passes", {31'd0, tx_grant}, 1);
        tx_req = 1'b0;

        // R4 prescale 00: 16 ticks -> 2
        wr(1'b1, 8'h04); ticks(16);
        check("R4 div8", {16'd0, ts_count}, 2);
        wr(1'b1, 8'h06); ticks(7);     // prescale 10, with clear
        check("R4 div2", {16'd0, ts_count}, 3);
        wr(1'b1, 8'h05); ticks(9);     // prescale 01
        check("R4 div4", {16'd0, ts_count}, 2);
        wr(1'b1, 8'h07); ticks(65535); // prescale 11
        check("R4 full", {16'd0, ts_count}, 32'hFFFF);
        ticks(1);
        check("R4 wrap", {16'd0, ts_count}, 0);

        // R8 status lag: leave init
        wr(1'b0, 8'h00); #0.5;
        check("R8 init now 0", {31'd0, init_mode}, 0);
        check("R8 sts still 1", {31'd0, in_reset}, 1);
        @(negedge clk); #0.5;
        check("R8 sts follows", {31'd0, in_reset}, 0);

        // R5 clear beats coincident tick
        ticks(5);
        check("R5 pre", {16'd0, ts_count}, 5);
        bit_tick = 1'b1;
        wr(1'b1, 8'h04);
        bit_tick = 1'b0;
        rd(1'b1, v);
        check("R5 cleared", {16'd0, ts_count}, 0);
        check("R5 bit set", {31'd0, v[2]}, 1);
        @(negedge clk); rd(1'b1, v);
        check("R5 self clear", {31'd0, v[2]}, 0);
        check("R3 ps kept", {30'd0, ts_scale}, 32'd3);

        // R9 increments and saturation
        tec_inc = 1'b1; rec_inc = 1'b1; @(negedge clk);
        @(negedge clk); rec_inc = 1'b0; @(negedge clk); tec_inc = 1'b0;
        check("R9 tec", {24'd0, tec}, 3);
        check("R9 rec", {24'd0, rec}, 2);
        tec_inc = 1'b1;
        for (int i = 0; i < 260; i++) @(negedge clk);
        tec_inc = 1'b0;
        check("R9 sat", {24'd0, tec}, 32'hFF);

        // R6 clear beats coincident strobes
        tec_inc = 1'b1; rec_inc = 1'b1;
        wr(1'b1, 8'h08);
        tec_inc = 1'b0; rec_inc = 1'b0;
        rd(1'b1, v);
        check("R6 cleared", {16'd0, tec, rec}, 0);
        check("R6 bit set", {31'd0, v[3]}, 1);
        @(negedge clk); rd(1'b1, v);
        check("R6 self clear", {31'd0, v[3]}, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule